// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block holds a set of machine-check error-reporting banks and the policy that records hardware errors into them. Each bank owns four 64-bit registers (control, status, address, auxiliary). Next to them sit a read-only capability word, a global control word and a global status word. An error source presents an injection for one cycle. The injection carries a bank index, a 64-bit status, a global-status value, an address and an auxiliary word. In that same cycle the block decides one of five outcomes: drop the event, log it in full, log it as a corrected error, only mark an overflow on the existing entry, or escalate to a fatal reset request.

An uncorrected error that is logged raises a machine-check interrupt request. The request stays high until it is acknowledged. An uncorrected error that arrives while a machine check is already in progress, or while machine-check delivery is disabled, records nothing. It produces a one-cycle reset request instead. Software reaches every register through a simple port that is decoded by register number. Reads are combinational and writes take effect at the clock edge.

Top module: `mce_bank_logger`

## Requirements
- R1: After reset the global control register and every bank control register read all ones. Every bank status, address and auxiliary register and the global status register read zero. The interrupt and reset requests are low.
- R2: The capability register (number 0x3F0) reads the bank count in bits 7:0 and a 1 in bit 8, which marks the global control register as present. Writes to it have no effect.
- R3: Bank i occupies register numbers 0x400+4i (control), 0x401+4i (status), 0x402+4i (address) and 0x403+4i (auxiliary). The global status register is 0x3F1 and the global control register is 0x3F2. Any other number reads zero, and a write to it changes no register.
- R4: A write to the global control register or to a bank control register takes effect only when the value is all zeros or all ones. Bank status, address, auxiliary and global status registers accept any value.
- R5: An injection changes nothing when its bank index is not less than the bank count, or when bit 63 (valid) of its status is clear.
- R6: An uncorrected injection (status bit 61 set) is dropped when the global control register is not all ones, or when the target bank's control register is not all ones.
- R7: An uncorrected injection that is not dropped logs nothing when global status bit 2 (in progress) is set or when `mce_en` is low. Instead `fatal_reset` is high for exactly the following cycle.
- R8: Otherwise an uncorrected injection writes the bank's address and auxiliary words, writes its status with bit 62 (overflow) also set if the old entry had bit 63 set, copies the injected global status into the global status register, and raises `mce_irq`.
- R9: A corrected injection (bit 61 clear) whose target entry is not both valid and uncorrected overwrites status, address and auxiliary, adding bit 62 if the old entry was valid. If the old entry is valid and uncorrected, only its bit 62 is set.
- R10: `mce_irq` stays high until a cycle with `irq_ack` high clears it. A new uncorrected log in the same cycle as an acknowledge keeps it high.
- R11: Injection decisions use the register values from before the current cycle. Where an injection and a register write touch the same register in one cycle, the injection's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mce_en | input | 1 | Machine-check delivery enabled by the core |
| inj_valid | input | 1 | One-cycle injection strobe |
| inj_bank | input | BANK_IN_W | Target bank index |
| inj_status | input | 64 | Injected bank status word |
| inj_gstatus | input | 64 | Global status value to record |
| inj_addr | input | 64 | Error address word |
| inj_misc | input | 64 | Auxiliary error word |
| irq_ack | input | 1 | Clears the interrupt request |
| reg_num | input | REG_W | Register number for read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for `reg_num` |
| mce_irq | output | 1 | Machine-check interrupt request (held) |
| fatal_reset | output | 1 | One-cycle reset request |

## Verification
The bench aims at the cases where a corrected error meets an existing uncorrected entry. A design that overwrote that entry would lose the address of the serious error, and one that forgot the overflow bit would hide the lost event. It injects an uncorrected error while the in-progress bit is set and while delivery is disabled; a faulty design would log the error and interrupt instead of requesting reset. It also writes non-uniform values to both kinds of control register and collides a register write, an acknowledge and an injection in one cycle, where a wrong priority shows up as a lost log or a dropped interrupt.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    localparam int WORD_W         = 64;
    localparam int VALID_BIT      = 63;
    localparam int OVF_BIT        = 62;
    localparam int UC_BIT         = 61;
    localparam int INPROG_BIT     = 2;
    localparam int CTL_PRES_BIT   = 8;

    // outcome of one injection
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_FATAL,
        ACT_LOG_UC,
        ACT_LOG_CE,
        ACT_MARK_OVF
    } inj_act_e;

    // register class selected by a register number
    typedef enum logic [2:0] {
        REG_NONE,
        REG_CAP,
        REG_GSTS,
        REG_GCTL,
        REG_BANK
    } reg_kind_e;

    // field order inside one bank; the decoder relies on this order
    typedef enum logic [1:0] {
        FLD_CTL = 2'd0,
        FLD_STS = 2'd1,
        FLD_ADR = 2'd2,
        FLD_MSC = 2'd3
    } bank_fld_e;

endpackage

// File: rtl/mcb_reg_decode.sv
module mcb_reg_decode
    import mcb_pkg::*;
#(
    parameter int               REG_W     = 16,
    parameter int               NUM_BANKS = 10,
    parameter int               IDX_W     = 4,
    parameter logic [REG_W-1:0] BANK_BASE = 16'h0400,
    parameter logic [REG_W-1:0] CAP_NUM   = 16'h03F0,
    parameter logic [REG_W-1:0] GSTS_NUM  = 16'h03F1,
    parameter logic [REG_W-1:0] GCTL_NUM  = 16'h03F2
) (
    input  logic [REG_W-1:0] reg_num,
    output reg_kind_e        kind,
    output logic [IDX_W-1:0] bank,
    output bank_fld_e        fld
);

    localparam logic [REG_W:0] BANK_END =
        (REG_W+1)'(BANK_BASE) + (REG_W+1)'(4 * NUM_BANKS);

    logic [REG_W-1:0] off;

    always_comb begin
        off  = reg_num - BANK_BASE;
        kind = REG_NONE;
        bank = '0;
        fld  = FLD_CTL;
        if (reg_num == CAP_NUM) begin
            kind = REG_CAP;
        end else if (reg_num == GSTS_NUM) begin
            kind = REG_GSTS;
        end else if (reg_num == GCTL_NUM) begin
            kind = REG_GCTL;
        end else if ((reg_num >= BANK_BASE) && ({1'b0, reg_num} < BANK_END)) begin
            kind = REG_BANK;
            bank = IDX_W'(off >> 2);
            fld  = bank_fld_e'(off[1:0]);
        end
    end

endmodule

// File: rtl/mcb_inject_eval.sv
module mcb_inject_eval
    import mcb_pkg::*;
#(
    parameter bit CTL_PRESENT = 1'b1
) (
    input  logic              inj_valid,
    input  logic              in_range,
    input  logic [WORD_W-1:0] inj_status,
    input  logic              mce_en,
    input  logic              gctl_ones,
    input  logic              gsts_inprog,
    input  logic              bank_ctl_ones,
    input  logic              old_valid,
    input  logic              old_uc,
    output inj_act_e          act,
    output logic [WORD_W-1:0] new_sts
);

    logic is_uc;
    logic uc_masked;

    always_comb begin
        is_uc     = inj_status[UC_BIT];
        uc_masked = (CTL_PRESENT && !gctl_ones) || !bank_ctl_ones;
        act       = ACT_NONE;
        new_sts   = inj_status;
        if (inj_valid && in_range && inj_status[VALID_BIT]) begin
            if (is_uc) begin
                if (uc_masked) begin
                    act = ACT_NONE;
                end else if (gsts_inprog || !mce_en) begin
                    act = ACT_FATAL;
                end else begin
                    act = ACT_LOG_UC;
                    if (old_valid) new_sts[OVF_BIT] = 1'b1;
                end
            end else if (!old_valid || !old_uc) begin
                act = ACT_LOG_CE;
                if (old_valid) new_sts[OVF_BIT] = 1'b1;
            end else begin
                act = ACT_MARK_OVF;
            end
        end
    end

endmodule

// File: rtl/mce_bank_logger.sv
module mce_bank_logger
    import mcb_pkg::*;
#(
    parameter int               NUM_BANKS   = 10,
    parameter int               BANK_IN_W   = 8,
    parameter int               REG_W       = 16,
    parameter logic [REG_W-1:0] BANK_BASE   = 16'h0400,
    parameter logic [REG_W-1:0] CAP_NUM     = 16'h03F0,
    parameter logic [REG_W-1:0] GSTS_NUM    = 16'h03F1,
    parameter logic [REG_W-1:0] GCTL_NUM    = 16'h03F2,
    parameter bit               CTL_PRESENT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mce_en,
    input  logic                 inj_valid,
    input  logic [BANK_IN_W-1:0] inj_bank,
    input  logic [63:0]          inj_status,
    input  logic [63:0]          inj_gstatus,
    input  logic [63:0]          inj_addr,
    input  logic [63:0]          inj_misc,
    input  logic                 irq_ack,
    input  logic [REG_W-1:0]     reg_num,
    input  logic                 reg_we,
    input  logic [63:0]          reg_wdata,
    output logic [63:0]          reg_rdata,
    output logic                 mce_irq,
    output logic                 fatal_reset
);

    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [WORD_W-1:0] CAP_VAL =
        WORD_W'(NUM_BANKS) | (CTL_PRESENT ? (WORD_W'(1) << CTL_PRES_BIT) : '0);

    typedef struct packed {
        logic [NUM_BANKS-1:0][WORD_W-1:0] ctl;
        logic [NUM_BANKS-1:0][WORD_W-1:0] sts;
        logic [NUM_BANKS-1:0][WORD_W-1:0] adr;
        logic [NUM_BANKS-1:0][WORD_W-1:0] msc;
        logic [WORD_W-1:0]                gctl;
        logic [WORD_W-1:0]                gsts;
        logic                             irq;
        logic                             fatal;
    } state_t;

    state_t state_d, state_q;

    // register decode
    reg_kind_e        rk_kind;
    logic [IDX_W-1:0] rk_bank;
    bank_fld_e        rk_fld;

    mcb_reg_decode #(
        .REG_W    (REG_W),
        .NUM_BANKS(NUM_BANKS),
        .IDX_W    (IDX_W),
        .BANK_BASE(BANK_BASE),
        .CAP_NUM  (CAP_NUM),
        .GSTS_NUM (GSTS_NUM),
        .GCTL_NUM (GCTL_NUM)
    ) u_dec (
        .reg_num(reg_num),
        .kind   (rk_kind),
        .bank   (rk_bank),
        .fld    (rk_fld)
    );

    // injection target selection
    logic             inj_in_range;
    logic [IDX_W-1:0] inj_idx;
    inj_act_e         inj_act;
    logic [63:0]      inj_new_sts;

    always_comb begin
        inj_in_range = (inj_bank < BANK_IN_W'(NUM_BANKS));
        inj_idx      = inj_in_range ? IDX_W'(inj_bank) : '0;
    end

    mcb_inject_eval #(
        .CTL_PRESENT(CTL_PRESENT)
    ) u_eval (
        .inj_valid    (inj_valid),
        .in_range     (inj_in_range),
        .inj_status   (inj_status),
        .mce_en       (mce_en),
        .gctl_ones    (state_q.gctl == '1),
        .gsts_inprog  (state_q.gsts[INPROG_BIT]),
        .bank_ctl_ones(state_q.ctl[inj_idx] == '1),
        .old_valid    (state_q.sts[inj_idx][VALID_BIT]),
        .old_uc       (state_q.sts[inj_idx][UC_BIT]),
        .act          (inj_act),
        .new_sts      (inj_new_sts)
    );

    // global control read variant
    logic [63:0] gctl_rd;
    generate
        if (CTL_PRESENT) begin : g_gctl_rd
            assign gctl_rd = state_q.gctl;
        end else begin : g_gctl_zero
            assign gctl_rd = '0;
        end
    endgenerate

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (rk_kind)
            REG_CAP:  reg_rdata = CAP_VAL;
            REG_GSTS: reg_rdata = state_q.gsts;
            REG_GCTL: reg_rdata = gctl_rd;
            REG_BANK: begin
                case (rk_fld)
                    FLD_CTL: reg_rdata = state_q.ctl[rk_bank];
                    FLD_STS: reg_rdata = state_q.sts[rk_bank];
                    FLD_ADR: reg_rdata = state_q.adr[rk_bank];
                    default: reg_rdata = state_q.msc[rk_bank];
                endcase
            end
            default:  reg_rdata = '0;
        endcase
    end

    // next state
    logic wr_uniform;

    always_comb begin
        state_d       = state_q;
        state_d.irq   = state_q.irq & ~irq_ack;
        state_d.fatal = 1'b0;
        wr_uniform    = (reg_wdata == '0) || (reg_wdata == '1);

        // register write first, so a same-cycle injection overrides it
        if (reg_we) begin
            case (rk_kind)
                REG_GSTS: state_d.gsts = reg_wdata;
                REG_GCTL: if (CTL_PRESENT && wr_uniform) state_d.gctl = reg_wdata;
                REG_BANK: begin
                    case (rk_fld)
                        FLD_CTL: if (wr_uniform) state_d.ctl[rk_bank] = reg_wdata;
                        FLD_STS: state_d.sts[rk_bank] = reg_wdata;
                        FLD_ADR: state_d.adr[rk_bank] = reg_wdata;
                        default: state_d.msc[rk_bank] = reg_wdata;
                    endcase
                end
                default: ;
            endcase
        end

        case (inj_act)
            ACT_FATAL: state_d.fatal = 1'b1;
            ACT_LOG_UC: begin
                state_d.sts[inj_idx] = inj_new_sts;
                state_d.adr[inj_idx] = inj_addr;
                state_d.msc[inj_idx] = inj_misc;
                state_d.gsts         = inj_gstatus;
                state_d.irq          = 1'b1;
            end
            ACT_LOG_CE: begin
                state_d.sts[inj_idx] = inj_new_sts;
                state_d.adr[inj_idx] = inj_addr;
                state_d.msc[inj_idx] = inj_misc;
            end
            ACT_MARK_OVF: state_d.sts[inj_idx][OVF_BIT] = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.ctl   <= '1;
            state_q.gctl  <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign mce_irq     = state_q.irq;
    assign fatal_reset = state_q.fatal;

    // R7
    fatal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_reset |-> $past(inj_valid && inj_status[UC_BIT] && inj_status[VALID_BIT]));

    // R7
    fatal_nolog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_reset && !$past(reg_we)) |-> ($stable(state_q.sts) && $stable(state_q.adr)));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mce_irq && !irq_ack) |=> mce_irq);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mce_irq) |-> $past(inj_valid && inj_status[UC_BIT] && inj_status[VALID_BIT]));

    // R5
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !inj_status[VALID_BIT] && !reg_we)
            |=> ($stable(state_q.sts) && $stable(state_q.gsts)));

    // R4
    gctl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && rk_kind == REG_GCTL && reg_wdata != '0 && reg_wdata != '1 && !inj_valid)
            |=> $stable(state_q.gctl));

endmodule

// File: tb/mce_bank_logger_test.sv
`timescale 1ns/1ps
module mce_bank_logger_test;

    localparam int          NB   = 10;
    localparam logic [63:0] ONES = '1;
    localparam logic [63:0] VB   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OB   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UB   = 64'h2000_0000_0000_0000;
    localparam logic [15:0] CAPN = 16'h03F0;
    localparam logic [15:0] GSTN = 16'h03F1;
    localparam logic [15:0] GCTN = 16'h03F2;
    localparam logic [15:0] BASE = 16'h0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mce_en = 1'b1;
    logic        inj_valid = 1'b0;
    logic [7:0]  inj_bank = '0;
    logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
    logic        irq_ack = 1'b0;
    logic [15:0] reg_num = '0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mce_irq, fatal_reset;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    mce_bank_logger uut (
        .clk(clk), .rst_n(rst_n), .mce_en(mce_en),
        .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
        .inj_gstatus(inj_gstatus), .inj_addr(inj_addr), .inj_misc(inj_misc),
        .irq_ack(irq_ack), .reg_num(reg_num), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mce_irq(mce_irq), .fatal_reset(fatal_reset)
    );

    // behavioural reference model
    logic [63:0] m_ctl [NB];
    logic [63:0] m_sts [NB];
    logic [63:0] m_adr [NB];
    logic [63:0] m_msc [NB];
    logic [63:0] m_gctl, m_gsts;
    logic        m_irq, m_fatal;

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            m_ctl[i] = ONES; m_sts[i] = '0; m_adr[i] = '0; m_msc[i] = '0;
        end
        m_gctl = ONES; m_gsts = '0; m_irq = 1'b0; m_fatal = 1'b0;
    endtask

    function automatic logic [63:0] model_read(input logic [15:0] n);
        int off;
        if (n == CAPN) return 64'(NB) | 64'h100;
        if (n == GSTN) return m_gsts;
        if (n == GCTN) return m_gctl;
        off = int'(n) - int'(BASE);
        if (off >= 0 && off < 4 * NB) begin
            case (off % 4)
                0: return m_ctl[off / 4];
                1: return m_sts[off / 4];
                2: return m_adr[off / 4];
                default: return m_msc[off / 4];
            endcase
        end
        return '0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int b;
            int off;
            logic [63:0] o_ctl, o_sts, o_gctl, o_gsts, s;
            logic n_irq, n_fat;
            b = int'(inj_bank);
            o_gctl = m_gctl;
            o_gsts = m_gsts;
            o_ctl = (b < NB) ? m_ctl[b] : '0;
            o_sts = (b < NB) ? m_sts[b] : '0;
            n_irq = m_irq && !irq_ack;
            n_fat = 1'b0;
            if (reg_we) begin
                off = int'(reg_num) - int'(BASE);
                if (reg_num == GSTN) m_gsts = reg_wdata;
                else if (reg_num == GCTN) begin
                    if (reg_wdata == '0 || reg_wdata == ONES) m_gctl = reg_wdata;
                end else if (off >= 0 && off < 4 * NB) begin
                    case (off % 4)
                        0: if (reg_wdata == '0 || reg_wdata == ONES) m_ctl[off / 4] = reg_wdata;
                        1: m_sts[off / 4] = reg_wdata;
                        2: m_adr[off / 4] = reg_wdata;
                        default: m_msc[off / 4] = reg_wdata;
                    endcase
                end
            end
            if (inj_valid && b < NB && inj_status[63]) begin
                s = inj_status;
                if (inj_status[61]) begin
                    if (o_gctl != ONES || o_ctl != ONES) begin
                        n_fat = 1'b0;
                    end else if (o_gsts[2] || !mce_en) begin
                        n_fat = 1'b1;
                    end else begin
                        if (o_sts[63]) s[62] = 1'b1;
                        m_sts[b] = s; m_adr[b] = inj_addr; m_msc[b] = inj_misc;
                        m_gsts = inj_gstatus;
                        n_irq = 1'b1;
                    end
                end else if (!o_sts[63] || !o_sts[61]) begin
                    if (o_sts[63]) s[62] = 1'b1;
                    m_sts[b] = s; m_adr[b] = inj_addr; m_msc[b] = inj_misc;
                end else begin
                    m_sts[b][62] = 1'b1;
                end
            end
            m_irq = n_irq;
            m_fatal = n_fat;
        end
    end

    // comparison every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            checks++;
            if (mce_irq !== m_irq) begin
                errors++;
                $display("FAIL %s mce_irq actual=%0b expected=%0b", cur_req, mce_irq, m_irq);
            end
            checks++;
            if (fatal_reset !== m_fatal) begin
                errors++;
                $display("FAIL %s fatal_reset actual=%0b expected=%0b", cur_req, fatal_reset, m_fatal);
            end
            checks++;
            if (reg_rdata !== model_read(reg_num)) begin
                errors++;
                $display("FAIL %s reg %h actual=%h expected=%h", cur_req, reg_num,
                         reg_rdata, model_read(reg_num));
            end
        end
    end

    // stimulus tasks: each starts and ends just after a falling edge
    task automatic rd(input logic [15:0] n);
        reg_num = n;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] n, input logic [63:0] v);
        reg_num = n; reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        rd(n);
    endtask

    task automatic inj(input int b, input logic [63:0] st, input logic [63:0] gs,
                       input logic [63:0] ad, input logic [63:0] mi);
        inj_valid = 1'b1; inj_bank = 8'(b); inj_status = st;
        inj_gstatus = gs; inj_addr = ad; inj_misc = mi;
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    task automatic sweep();
        rd(CAPN); rd(GSTN); rd(GCTN);
        for (int i = 0; i < 4 * NB; i++) rd(BASE + 16'(i));
        rd(BASE + 16'(4 * NB)); rd(16'h03FF);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1"; sweep();

        cur_req = "R2"; rd(CAPN); wr(CAPN, 64'h0); wr(CAPN, ONES);

        cur_req = "R3";
        wr(BASE + 16'd9, 64'hAAAA_0000_1111_2222);
        wr(BASE + 16'd10, 64'h1234_5678_9ABC_DEF0);
        wr(BASE + 16'd11, 64'h0F0F_0F0F_0F0F_0F0F);
        wr(BASE + 16'(4 * NB), 64'hDEAD);
        wr(16'h03FF, 64'hBEEF);
        sweep();

        cur_req = "R4";
        wr(BASE + 16'd12, 64'h5);
        wr(BASE + 16'd12, 64'h0);
        wr(BASE + 16'd12, 64'hFFFF_FFFF_0000_0000);
        wr(BASE + 16'd12, ONES);
        wr(GCTN, 64'h1234);
        wr(GCTN, 64'h0);
        wr(GCTN, ONES);
        wr(GSTN, 64'h0000_0000_0000_0300);
        wr(GSTN, 64'h0);
        wr(BASE + 16'd9, 64'h0);

        cur_req = "R5";
        inj(NB, VB | UB, 64'h4, 64'h11, 64'h22); rd(GSTN);
        inj(200, VB, 64'h4, 64'h11, 64'h22);
        inj(2, UB, 64'h4, 64'h11, 64'h22); rd(BASE + 16'd9);
        inj(2, 64'h7, 64'h0, 64'h11, 64'h22); rd(BASE + 16'd10);

        cur_req = "R6";
        wr(GCTN, 64'h0);
        inj(1, VB | UB | 64'h1, 64'h4, 64'h100, 64'h200); rd(BASE + 16'd5);
        wr(GCTN, ONES);
        wr(BASE + 16'd12, 64'h0);
        inj(3, VB | UB | 64'h2, 64'h4, 64'h100, 64'h200); rd(BASE + 16'd13);
        wr(BASE + 16'd12, ONES);

        cur_req = "R8";
        inj(1, VB | UB | 64'h33, 64'h5, 64'hA1, 64'hB1);
        rd(BASE + 16'd5); rd(BASE + 16'd6); rd(BASE + 16'd7); rd(GSTN);

        cur_req = "R10";
        repeat (3) rd(GSTN);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        rd(GSTN);

        cur_req = "R7";
        inj(4, VB | UB | 64'h44, 64'h0, 64'hC1, 64'hD1);
        rd(BASE + 16'd17); rd(BASE + 16'd18);
        wr(GSTN, 64'h0);
        mce_en = 1'b0;
        inj(4, VB | UB | 64'h45, 64'h0, 64'hC2, 64'hD2);
        rd(BASE + 16'd17);
        mce_en = 1'b1;
        inj(4, VB | UB | 64'h46, 64'h4, 64'hC3, 64'hD3);
        inj(5, VB | UB | 64'h47, 64'h0, 64'hC4, 64'hD4);
        rd(BASE + 16'd21);

        cur_req = "R8";
        wr(GSTN, 64'h0);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        inj(1, VB | UB | 64'h55, 64'h0, 64'hA2, 64'hB2);
        rd(BASE + 16'd5); rd(BASE + 16'd6);

        cur_req = "R9";
        inj(6, VB | 64'h61, 64'h0, 64'hE1, 64'hF1);
        rd(BASE + 16'd25);
        inj(6, VB | 64'h62, 64'h0, 64'hE2, 64'hF2);
        rd(BASE + 16'd25); rd(BASE + 16'd26);
        inj(1, VB | 64'h63, 64'h0, 64'hE3, 64'hF3);
        rd(BASE + 16'd5); rd(BASE + 16'd6); rd(BASE + 16'd7);
        wr(BASE + 16'd29, OB | 64'h1);
        inj(7, VB | 64'h64, 64'h0, 64'hE4, 64'hF4);
        rd(BASE + 16'd29);

        cur_req = "R10";
        rd(GSTN);
        wr(GSTN, 64'h0);
        irq_ack = 1'b1;
        inj(8, VB | UB | 64'h81, 64'h0, 64'h1, 64'h2);
        irq_ack = 1'b0;
        rd(BASE + 16'd33);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        rd(GSTN);

        cur_req = "R11";
        reg_num = BASE + 16'd37; reg_we = 1'b1; reg_wdata = 64'h1;
        inj(9, VB | 64'h91, 64'h0, 64'h3, 64'h4);
        reg_we = 1'b0;
        rd(BASE + 16'd37); rd(BASE + 16'd38);
        reg_num = BASE + 16'd36; reg_we = 1'b1; reg_wdata = 64'h0;
        inj(9, VB | UB | 64'h92, 64'h0, 64'h5, 64'h6);
        reg_we = 1'b0;
        rd(BASE + 16'd37); rd(BASE + 16'd36);
        wr(BASE + 16'd36, ONES);

        cur_req = "R1";
        sweep();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule